// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block gives a host sequential access to a small on-chip packet memory through one data port. The host loads a current address and a byte count, then issues port reads or port writes. Each access moves one byte, one little-endian 16-bit word or one 32-bit word. After each access the address steps forward and the count steps down. The address wraps from the ring's stop address back to its start address. When the count runs out, a sticky completion flag is raised.

The memory covers two windows: a short identification area at the bottom of the address space and a larger packet area at a parameterised base. An access whose bytes do not all fall inside one window touches nothing. A read of that kind returns ones across the access width. Writes are refused while the count is zero. Reads are still served then, and they still advance the address. Each port access takes one cycle, and read data comes back in the following cycle. A remote-transfer command issued with a zero count raises the completion flag at once.

Top module: `rdma_port`

## Requirements
- R1: After reset `cur_addr` is 0, `cur_cnt` is 0, `rdc` is 0 and `rd_valid` is 0.
- R2: The access size sets the step. With `port_long`=0 and `cfg_wide`=0 the access is one byte and steps by 1. With `port_long`=0 and `cfg_wide`=1 it is a 16-bit word and steps by 2. With `port_long`=1 it is a 32-bit word and steps by 4.
- R3: After an accepted access, the address becomes `cur_addr` plus the step. If that sum equals `ring_stop`, `ring_start` is loaded instead.
- R4: On an accepted access, a count less than or equal to the step becomes 0 and sets `rdc`. A larger count is reduced by the step.
- R5: A `port_wr` while `cur_cnt` is 0 changes no memory byte, no address, no count and no flag. A `port_rd` while `cur_cnt` is 0 still returns data, advances the address and sets `rdc`.
- R6: An access is valid only if all of its bytes lie below `PROM_BYTES`, or all lie in [`PMEM_BASE`, `PMEM_BASE`+`PMEM_BYTES`). An invalid read returns ones in the access width: 0x000000FF for a byte, 0x0000FFFF for a word, 0xFFFFFFFF for a 32-bit access. An invalid write is dropped.
- R7: For 16-bit and 32-bit accesses, address bit 0 is taken as 0 for the memory access. The step is still added to the unmodified address. Data is little-endian: the lowest address sits in bits 7:0.
- R8: A `cmd_stb` with `cmd_remote`=1 while `cur_cnt` is 0 sets `rdc` in the next cycle. With a non-zero count the command leaves `rdc` unchanged.
- R9: `rd_valid` is high for exactly the cycle after each `port_rd`, and `rd_data` is valid in that cycle.
- R10: `rdc` stays set until `rdc_clr` is pulsed. When a new completion and `rdc_clr` fall in the same cycle, `rdc` ends up set.
- R11: If `port_rd` and `port_wr` are both high in one cycle, only the read is performed. `ld_addr` and `ld_cnt` take priority over the address and count update of a same-cycle access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1 selects 16-bit narrow accesses, 0 selects byte accesses |
| ring_start | input | ADDR_W | First address of the ring |
| ring_stop | input | ADDR_W | Address one past the ring end |
| ld_addr | input | 1 | Load the current address |
| addr_val | input | ADDR_W | Value loaded by ld_addr |
| ld_cnt | input | 1 | Load the remaining byte count |
| cnt_val | input | CNT_W | Value loaded by ld_cnt |
| cmd_stb | input | 1 | Command strobe |
| cmd_remote | input | 1 | The command requests a remote read or write |
| rdc_clr | input | 1 | Clear the completion flag |
| port_rd | input | 1 | Data port read strobe |
| port_wr | input | 1 | Data port write strobe |
| port_long | input | 1 | 1 makes this access 32 bits wide |
| port_wdata | input | 32 | Write data, lowest address in bits 7:0 |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid |
| rdc | output | 1 | Sticky remote-transfer-complete flag |
| cur_addr | output | ADDR_W | Current remote address |
| cur_cnt | output | CNT_W | Remaining byte count |

## Verification
Two events can reach the completion flag in the same cycle: an access that exhausts the count, and a host clear. The bench first raises the flag with a zero-count command. It then loads a count of one and drives the final byte write together with `rdc_clr`. The flag must still read 1 afterwards, and it must drop only when a clear arrives alone. A second overlap is the ring wrap combined with an access size: a 16-bit or 32-bit access whose stepped address lands exactly on the stop address must come back at the ring start.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_WORD = 2'd1,
        ACC_LONG = 2'd2
    } acc_sz_e;

    typedef struct packed {
        logic [1:0] off;
        acc_sz_e    sz;
        logic       ok;
    } rd_tag_t;

    function automatic logic [2:0] step_of(acc_sz_e sz);
        case (sz)
            ACC_WORD: return 3'd2;
            ACC_LONG: return 3'd4;
            default:  return 3'd1;
        endcase
    endfunction

    function automatic logic [3:0] lane_mask(acc_sz_e sz);
        case (sz)
            ACC_WORD: return 4'b0011;
            ACC_LONG: return 4'b1111;
            default:  return 4'b0001;
        endcase
    endfunction

    function automatic logic [31:0] width_ones(acc_sz_e sz);
        case (sz)
            ACC_WORD: return 32'h0000_FFFF;
            ACC_LONG: return 32'hFFFF_FFFF;
            default:  return 32'h0000_00FF;
        endcase
    endfunction

endpackage

// File: rtl/rdma_lane.sv
module rdma_lane #(
    parameter int DEPTH = 264,
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             we,
    input  logic             re,
    input  logic [ROW_W-1:0] row,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[row] <= wdata;
        end
        if (re) begin
            rdata <= mem[row];
        end
    end

endmodule

// File: rtl/rdma_ptr.sv
module rdma_ptr #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_addr,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              ld_cnt,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [ADDR_W-1:0] ring_start,
    input  logic [ADDR_W-1:0] ring_stop,
    input  logic              adv,
    input  logic [2:0]        step,
    input  logic              cmd_stb,
    input  logic              cmd_remote,
    input  logic              rdc_clr,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              rdc_q
);

    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] addr_nx;
    logic [CNT_W-1:0]  cnt_nx;
    logic              last_acc;
    logic              set_done;

    always_comb begin
        sum      = addr_q + ADDR_W'(step);
        addr_nx  = (sum == ring_stop) ? ring_start : sum;
        last_acc = (cnt_q <= CNT_W'(step));
        cnt_nx   = last_acc ? '0 : cnt_q - CNT_W'(step);
        set_done = (adv && last_acc) ||
                   (cmd_stb && cmd_remote && (cnt_q == '0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
            rdc_q  <= 1'b0;
        end else begin
            if (ld_addr) begin
                addr_q <= addr_val;
            end else if (adv) begin
                addr_q <= addr_nx;
            end
            if (ld_cnt) begin
                cnt_q <= cnt_val;
            end else if (adv) begin
                cnt_q <= cnt_nx;
            end
            rdc_q <= (rdc_q && !rdc_clr) || set_done;
        end
    end

endmodule

// File: rtl/rdma_port.sv
module rdma_port #(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 16,
    parameter int PROM_BYTES = 32,
    parameter int PMEM_BASE  = 16384,
    parameter int PMEM_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wide,
    input  logic [ADDR_W-1:0] ring_start,
    input  logic [ADDR_W-1:0] ring_stop,
    input  logic              ld_addr,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              ld_cnt,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              cmd_stb,
    input  logic              cmd_remote,
    input  logic              rdc_clr,
    input  logic              port_rd,
    input  logic              port_wr,
    input  logic              port_long,
    input  logic [31:0]       port_wdata,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic              rdc,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt
);
    import rdma_pkg::*;

    localparam int PHYS_BYTES = PROM_BYTES + PMEM_BYTES;
    localparam int DEPTH      = PHYS_BYTES / LANES;
    localparam int ROW_W      = $clog2(DEPTH);
    localparam logic [31:0] PROM_END = 32'(PROM_BYTES);
    localparam logic [31:0] PM_LO    = 32'(PMEM_BASE);
    localparam logic [31:0] PM_HI    = 32'(PMEM_BASE + PMEM_BYTES);

    acc_sz_e           acc_sz;
    logic [2:0]        step;
    logic [3:0]        lmask;
    logic [ADDR_W-1:0] eff_addr;
    logic [31:0]       first;
    logic [31:0]       last;
    logic              in_prom;
    logic              in_pmem;
    logic              ok;
    logic [31:0]       phys_base;
    logic [1:0]        off;
    logic              do_wr;
    logic              adv;

    always_comb begin
        acc_sz   = port_long ? ACC_LONG : (cfg_wide ? ACC_WORD : ACC_BYTE);
        step     = step_of(acc_sz);
        lmask    = lane_mask(acc_sz);
        eff_addr = (acc_sz == ACC_BYTE) ? cur_addr : {cur_addr[ADDR_W-1:1], 1'b0};
        first    = 32'(eff_addr);
        last     = first + 32'(step) - 32'd1;
        in_prom  = (last < PROM_END);
        in_pmem  = (first >= PM_LO) && (last < PM_HI);
        ok       = in_prom || in_pmem;
        phys_base = in_prom ? first : (first - PM_LO + PROM_END);
        off      = phys_base[1:0];
        do_wr    = port_wr && !port_rd && (cur_cnt != '0);
        adv      = port_rd || do_wr;
    end

    rdma_ptr #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .ld_addr   (ld_addr),
        .addr_val  (addr_val),
        .ld_cnt    (ld_cnt),
        .cnt_val   (cnt_val),
        .ring_start(ring_start),
        .ring_stop (ring_stop),
        .adv       (adv),
        .step      (step),
        .cmd_stb   (cmd_stb),
        .cmd_remote(cmd_remote),
        .rdc_clr   (rdc_clr),
        .addr_q    (cur_addr),
        .cnt_q     (cur_cnt),
        .rdc_q     (rdc)
    );

    logic [7:0] lane_rd [LANES];

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [1:0]       k;
        logic [31:0]      bphys;
        logic [ROW_W-1:0] row;
        logic [7:0]       wbyte;
        logic             lane_we;

        always_comb begin
            k       = 2'(j) - off;
            bphys   = phys_base + 32'(k);
            row     = ok ? ROW_W'(bphys >> 2) : '0;
            wbyte   = port_wdata[{k, 3'b000} +: 8];
            lane_we = do_wr && ok && lmask[k];
        end

        rdma_lane #(
            .DEPTH(DEPTH),
            .ROW_W(ROW_W)
        ) u_ram (
            .clk  (clk),
            .we   (lane_we),
            .re   (port_rd),
            .row  (row),
            .wdata(wbyte),
            .rdata(lane_rd[j])
        );
    end

    rd_tag_t tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            tag_q    <= '{off: 2'd0, sz: ACC_BYTE, ok: 1'b0};
        end else begin
            rd_valid <= port_rd;
            if (port_rd) begin
                tag_q <= '{off: off, sz: acc_sz, ok: ok};
            end
        end
    end

    logic [31:0] gathered;
    logic [31:0] wones;

    always_comb begin
        gathered = '0;
        for (int k = 0; k < LANES; k++) begin
            gathered[8*k +: 8] = lane_rd[2'(tag_q.off + 2'(k))];
        end
        wones   = width_ones(tag_q.sz);
        rd_data = tag_q.ok ? (gathered & wones) : wones;
    end

endmodule

// File: rtl/rdma_port_chk.sv
module rdma_port_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wide,
    input logic              port_long,
    input logic              port_rd,
    input logic              port_wr,
    input logic              ld_addr,
    input logic              ld_cnt,
    input logic              cmd_stb,
    input logic              cmd_remote,
    input logic              rdc_clr,
    input logic [ADDR_W-1:0] ring_start,
    input logic [ADDR_W-1:0] ring_stop,
    input logic              rd_valid,
    input logic              rdc,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [CNT_W-1:0]  cur_cnt
);

    logic [CNT_W-1:0] stp;
    logic             acc;

    always_comb begin
        stp = port_long ? CNT_W'(4) : (cfg_wide ? CNT_W'(2) : CNT_W'(1));
        acc = port_rd || (port_wr && (cur_cnt != '0));
    end

    // R9
    rd_valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        port_rd |=> rd_valid);

    // R9
    rd_valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !port_rd |=> !rd_valid);

    // R5
    zero_cnt_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (port_wr && !port_rd && cur_cnt == '0 && !ld_addr && !ld_cnt)
        |=> ($stable(cur_addr) && $stable(cur_cnt)));

    // R4
    cnt_exhaust_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && cur_cnt <= stp && !ld_cnt) |=> (cur_cnt == '0 && rdc));

    // R4
    cnt_decrement_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && cur_cnt > stp && !ld_cnt) |=> (cur_cnt == $past(cur_cnt) - $past(stp)));

    // R8
    cmd_zero_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && cmd_remote && cur_cnt == '0) |=> rdc);

    // R10
    rdc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rdc && !rdc_clr) |=> rdc);

    // R3
    never_parks_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !ld_addr && ring_start != ring_stop) |=> (cur_addr != $past(ring_stop)));

endmodule

bind rdma_port rdma_port_chk #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wide  (cfg_wide),
    .port_long (port_long),
    .port_rd   (port_rd),
    .port_wr   (port_wr),
    .ld_addr   (ld_addr),
    .ld_cnt    (ld_cnt),
    .cmd_stb   (cmd_stb),
    .cmd_remote(cmd_remote),
    .rdc_clr   (rdc_clr),
    .ring_start(ring_start),
    .ring_stop (ring_stop),
    .rd_valid  (rd_valid),
    .rdc       (rdc),
    .cur_addr  (cur_addr),
    .cur_cnt   (cur_cnt)
);

// File: tb/tb_rdma_port.sv
module tb_rdma_port;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wide;
    logic [15:0] ring_start;
    logic [15:0] ring_stop;
    logic        ld_addr;
    logic [15:0] addr_val;
    logic        ld_cnt;
    logic [15:0] cnt_val;
    logic        cmd_stb;
    logic        cmd_remote;
    logic        rdc_clr;
    logic        port_rd;
    logic        port_wr;
    logic        port_long;
    logic [31:0] port_wdata;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        rdc;
    logic [15:0] cur_addr;
    logic [15:0] cur_cnt;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    rdma_port dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_wide  (cfg_wide),
        .ring_start(ring_start),
        .ring_stop (ring_stop),
        .ld_addr   (ld_addr),
        .addr_val  (addr_val),
        .ld_cnt    (ld_cnt),
        .cnt_val   (cnt_val),
        .cmd_stb   (cmd_stb),
        .cmd_remote(cmd_remote),
        .rdc_clr   (rdc_clr),
        .port_rd   (port_rd),
        .port_wr   (port_wr),
        .port_long (port_long),
        .port_wdata(port_wdata),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .rdc       (rdc),
        .cur_addr  (cur_addr),
        .cur_cnt   (cur_cnt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] a, input logic [15:0] c);
        @(negedge clk);
        ld_addr = 1'b1; addr_val = a; ld_cnt = 1'b1; cnt_val = c;
        @(negedge clk);
        ld_addr = 1'b0; ld_cnt = 1'b0;
    endtask

    task automatic wr(input logic lng, input logic [31:0] d, input logic clr);
        @(negedge clk);
        port_wr = 1'b1; port_long = lng; port_wdata = d; rdc_clr = clr;
        @(negedge clk);
        port_wr = 1'b0; port_long = 1'b0; rdc_clr = 1'b0;
    endtask

    task automatic rd(input logic lng, output logic [31:0] d);
        @(negedge clk);
        port_rd = 1'b1; port_long = lng;
        @(negedge clk);
        port_rd = 1'b0; port_long = 1'b0;
        check("R9 rd_valid after read", 32'(rd_valid), 32'd1);
        d = rd_data;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        rdc_clr = 1'b1;
        @(negedge clk);
        rdc_clr = 1'b0;
    endtask

    task automatic command();
        @(negedge clk);
        cmd_stb = 1'b1; cmd_remote = 1'b1;
        @(negedge clk);
        cmd_stb = 1'b0; cmd_remote = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 addr", 32'(cur_addr), 32'd0);
        check("R1 cnt", 32'(cur_cnt), 32'd0);
        check("R1 rdc", 32'(rdc), 32'd0);
        check("R1 rd_valid", 32'(rd_valid), 32'd0);
    endtask

    task automatic t_steps_and_endian();
        logic [31:0] d;
        cfg_wide = 1'b0;
        load(16'h4000, 16'd4);
        wr(1'b0, 32'h11, 1'b0);
        check("R4 count minus one", 32'(cur_cnt), 32'd3);
        check("R2 byte step", 32'(cur_addr), 32'h4001);
        wr(1'b0, 32'h22, 1'b0);
        wr(1'b0, 32'h33, 1'b0);
        check("R4 no flag before end", 32'(rdc), 32'd0);
        wr(1'b0, 32'h44, 1'b0);
        check("R4 count exhausted", 32'(cur_cnt), 32'd0);
        check("R4 flag on exhaustion", 32'(rdc), 32'd1);
        clear_flag();
        check("R10 clear alone", 32'(rdc), 32'd0);
        load(16'h4000, 16'd16);
        rd(1'b1, d);
        check("R7 little-endian long", d, 32'h44332211);
        check("R2 long step", 32'(cur_addr), 32'h4004);
        check("R4 count minus four", 32'(cur_cnt), 32'd12);
        @(negedge clk);
        check("R9 rd_valid one cycle", 32'(rd_valid), 32'd0);
        cfg_wide = 1'b1;
        load(16'h4001, 16'd16);
        rd(1'b0, d);
        check("R7 odd word address aligned", d, 32'h00002211);
        check("R7 step from unaligned address", 32'(cur_addr), 32'h4003);
        check("R2 word step count", 32'(cur_cnt), 32'd14);
        cfg_wide = 1'b0;
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        cfg_wide = 1'b1;
        load(16'h400E, 16'd8);
        wr(1'b0, 32'h0000BEEF, 1'b0);
        check("R3 word wraps to start", 32'(cur_addr), 32'h4000);
        load(16'h400E, 16'd8);
        rd(1'b0, d);
        check("R3 data before wrap", d, 32'h0000BEEF);
        load(16'h400C, 16'd8);
        rd(1'b1, d);
        check("R3 long wraps to start", 32'(cur_addr), 32'h4000);
        cfg_wide = 1'b0;
    endtask

    task automatic t_zero_count();
        logic [31:0] d;
        load(16'h4020, 16'd1);
        wr(1'b0, 32'h5A, 1'b0);
        clear_flag();
        load(16'h4020, 16'd0);
        wr(1'b0, 32'hA5, 1'b0);
        check("R5 write ignored addr", 32'(cur_addr), 32'h4020);
        check("R5 write ignored cnt", 32'(cur_cnt), 32'd0);
        check("R5 write ignored flag", 32'(rdc), 32'd0);
        rd(1'b0, d);
        check("R5 memory unchanged", d, 32'h0000005A);
        check("R5 read advances", 32'(cur_addr), 32'h4021);
        check("R5 read sets flag", 32'(rdc), 32'd1);
        clear_flag();
    endtask

    task automatic t_windows();
        logic [31:0] d;
        load(16'h0100, 16'd8);
        rd(1'b0, d);
        check("R6 byte outside reads ones", d, 32'h000000FF);
        load(16'h0104, 16'd8);
        rd(1'b1, d);
        check("R6 long outside reads ones", d, 32'hFFFFFFFF);
        cfg_wide = 1'b1;
        load(16'h43FE, 16'd8);
        wr(1'b0, 32'h0000CAFE, 1'b0);
        load(16'h43FE, 16'd8);
        wr(1'b1, 32'h11111111, 1'b0);
        load(16'h43FE, 16'd8);
        rd(1'b0, d);
        check("R6 crossing write dropped", d, 32'h0000CAFE);
        load(16'h43FE, 16'd8);
        rd(1'b1, d);
        check("R6 crossing long read ones", d, 32'hFFFFFFFF);
        cfg_wide = 1'b0;
        load(16'h001F, 16'd4);
        wr(1'b0, 32'h77, 1'b0);
        load(16'h001F, 16'd4);
        rd(1'b0, d);
        check("R6 low window byte", d, 32'h00000077);
        load(16'h001E, 16'd4);
        rd(1'b1, d);
        check("R6 long past low window", d, 32'hFFFFFFFF);
        clear_flag();
    endtask

    task automatic t_command();
        load(16'h4000, 16'd0);
        command();
        check("R8 zero count command sets flag", 32'(rdc), 32'd1);
        clear_flag();
        load(16'h4000, 16'd5);
        command();
        check("R8 nonzero count command no flag", 32'(rdc), 32'd0);
    endtask

    task automatic t_set_and_clear();
        logic [31:0] d;
        load(16'h4000, 16'd0);
        command();
        load(16'h4030, 16'd1);
        wr(1'b0, 32'h3C, 1'b1);
        check("R10 set wins over clear", 32'(rdc), 32'd1);
        check("R4 count zero after last", 32'(cur_cnt), 32'd0);
        clear_flag();
        check("R10 later clear", 32'(rdc), 32'd0);
        load(16'h4030, 16'd4);
        @(negedge clk);
        port_rd = 1'b1; port_wr = 1'b1; port_wdata = 32'hC3;
        @(negedge clk);
        port_rd = 1'b0; port_wr = 1'b0;
        check("R11 read wins data", rd_data, 32'h0000003C);
        check("R11 single step", 32'(cur_addr), 32'h4031);
        load(16'h4030, 16'd4);
        rd(1'b0, d);
        check("R11 write not performed", d, 32'h0000003C);
        @(negedge clk);
        port_rd = 1'b1; ld_addr = 1'b1; addr_val = 16'h4100;
        @(negedge clk);
        port_rd = 1'b0; ld_addr = 1'b0;
        check("R11 load wins over advance", 32'(cur_addr), 32'h4100);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_wide = 1'b0;
        ring_start = 16'h4000; ring_stop = 16'h4010;
        ld_addr = 1'b0; addr_val = '0; ld_cnt = 1'b0; cnt_val = '0;
        cmd_stb = 1'b0; cmd_remote = 1'b0; rdc_clr = 1'b0;
        port_rd = 1'b0; port_wr = 1'b0; port_long = 1'b0; port_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_steps_and_endian();
        t_wrap();
        t_zero_count();
        t_windows();
        t_command();
        t_set_and_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule